// File: doc/BRIEF.md
# Gated serial word receiver

This block sits on the receiving end of a three-wire serial link: an active-low gate, a burst clock and a data line. All three lines are brought into a faster local clock domain through synchronisers. While the gate is low, every falling edge of the burst clock shifts one data bit into a 16-bit register. The first bit received becomes the most significant bit of the word.

When the gate is released, the block looks at how many bits it received. If it received exactly sixteen, it presents the word together with a single-cycle valid strobe. Any other count produces a single-cycle framing-error strobe, and the output word is left as it was.

While the gate is high, the clock and data lines may toggle freely, for example when other receivers share them. The block takes no notice of them in that state. The local clock must run at least eight times faster than the bit rate.

Top module: `gsr_rx`

## Requirements
- R1: After synchronous reset, `word_o` is 0, and `valid_o` and `frame_err_o` are both 0.
- R2: Bits are sampled on falling edges of `sclk_i` while `gate_n_i` is low. The first bit sampled lands in `word_o[15]` and the sixteenth lands in `word_o[0]`.
- R3: When `gate_n_i` rises after exactly 16 samples, `word_o` takes the received word and `valid_o` is high for exactly one cycle.
- R4: When `gate_n_i` rises after fewer than 16 samples, `frame_err_o` is high for exactly one cycle, `valid_o` stays low and `word_o` keeps its previous value.
- R5: A 17th or later falling edge in the same gate-low window is not shifted in. It makes the transfer end with a framing error, and `word_o` is unchanged.
- R6: While `gate_n_i` is high, activity on `sclk_i` and `sdata_i` produces no strobe and does not change `word_o`.
- R7: A gap of any length between the 8th and 9th clock pulses is accepted, and the word is still delivered with `valid_o`.
- R8: The gate may rise while `sclk_i` is still low after the 16th falling edge. The word is delivered without the receiver waiting for the final rising edge.
- R9: A clock falling edge that reaches the local domain in the same cycle as the gate fall counts as a sample. A falling edge that reaches it in the same cycle as the gate rise is not counted.
- R10: `valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, at least 8x the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| gate_n_i | input | 1 | Transfer gate, active low, asynchronous to clk |
| sclk_i | input | 1 | Burst clock; data is sampled on its falling edges |
| sdata_i | input | 1 | Serial data, most significant bit first |
| word_o | output | 16 | Last correctly received word |
| valid_o | output | 1 | One-cycle strobe when a new word is placed on `word_o` |
| frame_err_o | output | 1 | One-cycle strobe when a transfer ends with a bit count other than 16 |

## Verification
Two events can fall in the same synchronised cycle: a clock falling edge and a gate transition. The bench creates both cases by changing the gate and the clock at the same instant. In the first case, the gate falls with the first falling edge of the clock. That transfer must still deliver its word with a valid strobe, with the first bit in the top position. In the second case, the gate rises with the sixteenth falling edge. That edge must be dropped, so the scoreboard expects a framing error and an unchanged word.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    // Synchronised view of the three line signals
    typedef struct packed {
        logic gate_n;
        logic sclk;
        logic sdata;
    } line_t;

    // Idle line state: gate released, clock high, data low
    localparam line_t LINE_IDLE = '{gate_n: 1'b1, sclk: 1'b1, sdata: 1'b0};

    typedef enum logic [1:0] {
        EV_NONE      = 2'd0,
        EV_WORD      = 2'd1,
        EV_FRAME_ERR = 2'd2
    } end_event_e;

    // Decide how a closed window ends, from its bit count and overrun flag
    function automatic end_event_e judge_window(input int unsigned cnt,
                                                input logic overrun,
                                                input int unsigned width);
        if (!overrun && cnt == width)
            return EV_WORD;
        return EV_FRAME_ERR;
    endfunction

endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
    parameter int unsigned        STAGES = 2,
    parameter int unsigned        W      = 3,
    parameter logic [W-1:0]       RST    = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gsr_edge.sv
module gsr_edge
    import gsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t cur,
    output logic  bit_stb,
    output logic  bit_val,
    output logic  win_open,
    output logic  win_close
);

    line_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= LINE_IDLE;
        else     prev <= cur;
    end

    // Gate low in the current synchronised sample means the window is open
    assign win_open  = !cur.gate_n;
    assign win_close = cur.gate_n && !prev.gate_n;
    // A clock fall counts only while the gate is low in the same sample
    assign bit_stb   = prev.sclk && !cur.sclk && !cur.gate_n;
    assign bit_val   = cur.sdata;

endmodule

// File: rtl/gsr_shift.sv
module gsr_shift
    import gsr_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              win_open,
    input  logic              win_close,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              err_o
);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              overrun;
    end_event_e        verdict;

    assign verdict = win_close ? judge_window(int'(cnt), overrun, WORD_W) : EV_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else if (!win_open) begin
            cnt     <= '0;
            overrun <= 1'b0;
        end else if (bit_stb) begin
            if (cnt == CNT_W'(WORD_W)) begin
                overrun <= 1'b1;
            end else begin
                shreg <= {shreg[WORD_W-2:0], bit_val};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= (verdict == EV_WORD);
            err_o   <= (verdict == EV_FRAME_ERR);
            if (verdict == EV_WORD)
                word_o <= shreg;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W)); // R5
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (overrun && win_open) |=> overrun); // R5

endmodule

// File: rtl/gsr_rx.sv
module gsr_rx
    import gsr_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate_n_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              frame_err_o
);

    localparam int unsigned LINE_W = $bits(line_t);

    line_t line_raw;
    line_t line_syn;
    logic  bit_stb, bit_val, win_open, win_close;

    assign line_raw = '{gate_n: gate_n_i, sclk: sclk_i, sdata: sdata_i};

    gsr_sync #(.STAGES(SYNC_STAGES), .W(LINE_W), .RST(LINE_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw),
        .q   (line_syn)
    );

    gsr_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .cur       (line_syn),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .win_open  (win_open),
        .win_close (win_close)
    );

    gsr_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .win_open  (win_open),
        .win_close (win_close),
        .word_o    (word_o),
        .valid_o   (valid_o),
        .err_o     (frame_err_o)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && frame_err_o)); // R10
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R3
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o); // R4
    AST_WORD_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_o) |-> valid_o); // R6
    AST_NO_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        win_open |=> !(valid_o || frame_err_o)); // R6

endmodule

// File: tb/gsr_rx_test.sv
module gsr_rx_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        gate_n, sclk, sdata;
    logic [15:0] word;
    logic        valid, ferr;

    int tests = 0;
    int fails = 0;

    typedef struct {
        bit          is_err;
        logic [15:0] w;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] last_good = 16'h0;

    always #2.5 clk = ~clk;

    gsr_rx uut (
        .clk(clk), .rst(rst), .gate_n_i(gate_n), .sclk_i(sclk), .sdata_i(sdata),
        .word_o(word), .valid_o(valid), .frame_err_o(ferr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per observed strobe
    always @(negedge clk) begin
        if (!rst && (valid || ferr)) begin
            check(!(valid && ferr), "R10", "both strobes", {valid, ferr}, 0);
            if (sb.size() == 0) begin
                check(0, "R6", "unexpected strobe", {valid, ferr}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ferr == e.is_err && valid == !e.is_err, e.tag, "strobe kind",
                      {valid, ferr}, {!e.is_err, e.is_err});
                if (!e.is_err)
                    check(word == e.w, e.tag, "word", word, e.w);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits from stream (MSB first). first_co: gate falls with first clock fall.
    // last_co: gate rises with last clock fall.
    task automatic xfer(input logic [31:0] stream, input int n, input int gap8,
                        input bit first_co, input bit last_co, input string tag);
        int   counted;
        exp_t e;
        counted = last_co ? n - 1 : n;
        e.is_err = (counted != 16);
        e.w      = stream[31:16];
        e.tag    = tag;
        @(negedge clk);
        sdata = stream[31];
        if (first_co) begin
            @(negedge clk);
            gate_n = 1'b0;
            sclk   = 1'b0;
        end else begin
            @(negedge clk);
            gate_n = 1'b0;
            wait_n(3);
        end
        for (int i = 0; i < n; i++) begin
            bit co_last;
            co_last = last_co && (i == n - 1);
            if (!(first_co && i == 0)) begin
                sdata = stream[31-i];
                wait_n(2);
                if (co_last) begin
                    sb.push_back(e);
                    gate_n = 1'b1;
                end
                sclk = 1'b0;
            end
            wait_n(4);
            if (i == n - 1 && !last_co) begin
                sb.push_back(e);
                gate_n = 1'b1;   // released before last rising edge (R8)
                wait_n(2);
            end
            sclk = 1'b1;
            wait_n(4);
            if (i == 7) wait_n(gap8);
        end
        wait_n(10);
        if (!e.is_err) last_good = e.w;
        check(word == last_good, tag, "word after transfer", word, last_good);
    endtask

    task automatic noise(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            sclk  = ~sclk;
            sdata = (i % 3) == 0;
        end
        @(negedge clk);
        sclk = 1'b1;
        wait_n(8);
        check(word == last_good, "R6", "word after idle noise", word, last_good);
    endtask

    initial begin
        rst = 1'b1; gate_n = 1'b1; sclk = 1'b1; sdata = 1'b0;
        wait_n(4);
        check(word == 16'h0, "R1", "reset word", word, 0);
        check(valid == 1'b0, "R1", "reset valid", valid, 0);
        check(ferr == 1'b0, "R1", "reset ferr", ferr, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_n(4);
        xfer(32'hA5C3_0000, 16, 0, 0, 0, "R3");
        xfer(32'h8001_0000, 16, 0, 0, 0, "R2");
        noise(40);                                    // R6
        xfer(32'h3C7E_0000, 16, 60, 0, 0, "R7");
        xfer(32'h1234_0000, 15, 0, 0, 0, "R4");
        xfer(32'hFFFF_8000, 17, 0, 0, 0, "R5");
        xfer(32'h0F0F_0000, 16, 0, 0, 0, "R8");
        xfer(32'hC001_0000, 16, 0, 1, 0, "R9");        // first edge with gate fall counts
        xfer(32'h5555_0000, 16, 0, 0, 1, "R9");        // last edge with gate rise dropped
        xfer(32'h0000_0000, 0, 0, 0, 0, "R4");
        wait_n(10);
        check(sb.size() == 0, "R3", "pending expected strobes", sb.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule